// File: doc/BRIEF.md
# Compact Multicycle 8-bit Processor

The block is a small multicycle processor with four 8-bit general registers, four condition flags and a stack pointer. It moves one byte per transaction over an external synchronous byte memory port. Every instruction is a 16-bit word held big-endian in two consecutive bytes. Memory-access and control-flow instructions are followed by a 16-bit big-endian address word, which is truncated to the configured address width. Arithmetic, logic, shift, multiply and divide instructions read two registers and write one.

After reset the core fetches from address zero and runs until it executes a halt. It then raises `halted`, stops using the bus and keeps all state until the next reset. A subroutine call pushes its return address onto a downward-growing stack that starts at the top of the address space. There is no return instruction. Results are made visible by storing them to memory.

Top module: `acc8_core`

## Requirements
- R1: Reset clears PC, all four registers and the flags (Z, N, C, V) to zero and sets SP to all ones of the address width. The first bus request after reset is a read of address 0, and `halted` is low.
- R2: The instruction word is opcode[15:12], rd[11:10], rs[9:8], imm[7:0]. The byte at PC is the high byte and the byte at PC+1 is the low byte. Opcodes 0xA to 0xE also fetch a big-endian address word from PC+2 and PC+3. That word is used modulo 2^AW, so the bits above the address width are ignored.
- R3: ADD (opcode 0) writes (rd+rs) mod 256 to rd. It sets Z when the result is 0, N from result bit 7 and C from the carry-out. It sets V when both operands have the same sign and the result has the other sign.
- R4: SUB (opcode 1) writes rd−rs mod 256 to rd. C is set when rd ≥ rs unsigned (no borrow). V is set when the operand signs differ and the result sign differs from rd. Z and N follow the result.
- R5: AND, OR and XOR (opcodes 2, 3, 4) write the bitwise result to rd and leave all flags unchanged.
- R6: SHL and SHR (opcodes 5, 6) shift rd by one place with a zero fill and leave the flags unchanged.
- R7: MUL (opcode 7) writes the low 8 bits of the product, sets Z and N from it, and clears C and V. DIV (opcode 8) writes the unsigned quotient, or 0xFF when the divisor is zero, and leaves the flags unchanged.
- R8: CMP (opcode 9) sets all four flags exactly as SUB would and leaves rd unchanged.
- R9: LOAD (0xA) writes the memory byte at the address into rd. STORE (0xB) writes register rs to that address. Both continue at PC+4.
- R10: JMP (0xC) continues at the address. JCC (0xD) takes condition imm[2:0], where 0 is Z, 2 is C, 4 is N and 6 is V, and each odd code is the inverse of the even code below it. When the condition holds, JCC continues at the address, otherwise at PC+4. Flags are unchanged.
- R11: CALL (0xE) decrements SP, writes the high byte of the 16-bit zero-extended PC+4, decrements SP again, writes the low byte, and continues at the address.
- R12: HALT (0xF) raises `halted`. From then on no bus request is made and `halted` stays high until reset.
- R13: Each transaction moves one byte. A request holds `mem_req`, `mem_we` and `mem_addr` steady until it sees `mem_ready`, and read data is taken in the cycle `mem_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Byte transaction requested |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Transaction completes this cycle |
| halted | output | 1 | Core has executed HALT |

## Verification
Every flag is checked through conditional branches, using both the even and the inverted condition codes. A core that swapped a flag, inverted the sense of the subtract carry, or let logic ops or DIV disturb the flags would store the wrong flag byte. Directed cases cover signed overflow on add and subtract, zero results with carry, a zero divisor and shifts with a one in the edge bits, so a core with a wrong overflow rule or a rotating shift would report a bad result. Address words carry random bits above the address width, so any decoder that does not truncate them would access the wrong byte. A call from a return address with a non-zero high byte catches pushes in the wrong order. Random memory latency catches a request that changes before it is accepted.

// File: rtl/acc8_pkg.sv
package acc8_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int NREGS  = 4;

    typedef enum logic [3:0] {
        OP_ADD   = 4'h0,
        OP_SUB   = 4'h1,
        OP_AND   = 4'h2,
        OP_OR    = 4'h3,
        OP_XOR   = 4'h4,
        OP_SHL   = 4'h5,
        OP_SHR   = 4'h6,
        OP_MUL   = 4'h7,
        OP_DIV   = 4'h8,
        OP_CMP   = 4'h9,
        OP_LOAD  = 4'hA,
        OP_STORE = 4'hB,
        OP_JMP   = 4'hC,
        OP_JCC   = 4'hD,
        OP_CALL  = 4'hE,
        OP_HALT  = 4'hF
    } op_e;

    typedef enum logic [2:0] {
        PH_FETCH,
        PH_EXEC,
        PH_DATA,
        PH_PUSH_HI,
        PH_PUSH_LO,
        PH_STOP
    } phase_e;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/acc8_alu.sv
module acc8_alu
    import acc8_pkg::*;
#(
    parameter int DW = 8
) (
    input  op_e           op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  flags_t        fl_in,
    output logic [DW-1:0] res,
    output flags_t        fl_out
);

    logic [DW:0]   sum;
    logic [DW:0]   dif;
    logic [DW-1:0] prod;

    always_comb begin
        sum    = {1'b0, a} + {1'b0, b};
        dif    = {1'b0, a} + {1'b0, ~b} + (DW+1)'(1);
        prod   = a * b;
        res    = a;
        fl_out = fl_in;
        case (op)
            OP_ADD: begin
                res      = sum[DW-1:0];
                fl_out.c = sum[DW];
                fl_out.v = (a[DW-1] ^ sum[DW-1]) & (b[DW-1] ^ sum[DW-1]);
            end
            OP_SUB, OP_CMP: begin
                res      = dif[DW-1:0];
                fl_out.c = dif[DW];
                fl_out.v = (a[DW-1] ^ b[DW-1]) & (a[DW-1] ^ dif[DW-1]);
            end
            OP_MUL: begin
                res      = prod;
                fl_out.c = 1'b0;
                fl_out.v = 1'b0;
            end
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_SHL: res = {a[DW-2:0], 1'b0};
            OP_SHR: res = {1'b0, a[DW-1:1]};
            OP_DIV: res = (b == '0) ? '1 : a / b;
            default: ;
        endcase
        if (op == OP_ADD || op == OP_SUB || op == OP_CMP || op == OP_MUL) begin
            fl_out.z = (res == '0);
            fl_out.n = res[DW-1];
        end
    end

endmodule

// File: rtl/acc8_regs.sv
module acc8_regs #(
    parameter int NREG = 4,
    parameter int DW   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] waddr,
    input  logic [DW-1:0]           wdata,
    input  logic [$clog2(NREG)-1:0] raddr_a,
    input  logic [$clog2(NREG)-1:0] raddr_b,
    output logic [DW-1:0]           rdata_a,
    output logic [DW-1:0]           rdata_b
);

    localparam int AB = $clog2(NREG);

    logic [NREG-1:0][DW-1:0] bank;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] val_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                val_q <= '0;
            else if (we && waddr == AB'(g))
                val_q <= wdata;
        end
        assign bank[g] = val_q;
    end

    assign rdata_a = bank[raddr_a];
    assign rdata_b = bank[raddr_b];

endmodule

// File: rtl/acc8_core.sv
module acc8_core
    import acc8_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    input  logic          mem_ready,
    output logic          halted
);

    localparam int RAB = $clog2(NREGS);

    typedef struct packed {
        phase_e              phase;
        logic [1:0]          cnt;
        logic [AW-1:0]       pc;
        logic [AW-1:0]       sp;
        logic [WORD_W-1:0]   ir;
        logic [WORD_W-1:0]   aw;
        flags_t              fl;
    } core_t;

    core_t st_q, st_d;

    op_e             op;
    logic [RAB-1:0]  rd_idx, rs_idx;
    logic [BYTE_W-1:0] rd_val, rs_val, alu_res, rf_wdata;
    flags_t          alu_fl;
    logic            rf_we;
    logic            has_addr, jcc_sel, jcc_taken;
    logic [AW-1:0]   tgt, pc2, pc4;
    logic [WORD_W-1:0] ret_word;

    assign op       = op_e'(st_q.ir[15:12]);
    assign rd_idx   = st_q.ir[11:10];
    assign rs_idx   = st_q.ir[9:8];
    assign has_addr = (st_q.ir[15:12] >= 4'hA) && (st_q.ir[15:12] <= 4'hE);
    assign tgt      = st_q.aw[AW-1:0];
    assign pc2      = st_q.pc + AW'(2);
    assign pc4      = st_q.pc + AW'(4);
    assign halted   = (st_q.phase == PH_STOP);

    always_comb begin
        ret_word         = '0;
        ret_word[AW-1:0] = pc4;
    end

    always_comb begin
        case (st_q.ir[2:1])
            2'd0:    jcc_sel = st_q.fl.z;
            2'd1:    jcc_sel = st_q.fl.c;
            2'd2:    jcc_sel = st_q.fl.n;
            default: jcc_sel = st_q.fl.v;
        endcase
        jcc_taken = jcc_sel ^ st_q.ir[0];
    end

    logic unused_bits;
    assign unused_bits = ^{st_q.aw, st_q.ir};

    acc8_regs #(.NREG(NREGS), .DW(BYTE_W)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (rd_idx),
        .wdata   (rf_wdata),
        .raddr_a (rd_idx),
        .raddr_b (rs_idx),
        .rdata_a (rd_val),
        .rdata_b (rs_val)
    );

    acc8_alu #(.DW(BYTE_W)) i_alu (
        .op     (op),
        .a      (rd_val),
        .b      (rs_val),
        .fl_in  (st_q.fl),
        .res    (alu_res),
        .fl_out (alu_fl)
    );

    assign rf_wdata = (st_q.phase == PH_DATA) ? mem_rdata : alu_res;

    always_comb begin
        st_d      = st_q;
        rf_we     = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = st_q.pc + AW'(st_q.cnt);
        mem_wdata = rs_val;
        case (st_q.phase)
            PH_FETCH: begin
                mem_req = 1'b1;
                if (mem_ready) begin
                    case (st_q.cnt)
                        2'd0: begin
                            st_d.ir[15:8] = mem_rdata;
                            st_d.cnt      = 2'd1;
                        end
                        2'd1: begin
                            st_d.ir[7:0] = mem_rdata;
                            if (has_addr) begin
                                st_d.cnt = 2'd2;
                            end else begin
                                st_d.cnt   = 2'd0;
                                st_d.phase = PH_EXEC;
                            end
                        end
                        2'd2: begin
                            st_d.aw[15:8] = mem_rdata;
                            st_d.cnt      = 2'd3;
                        end
                        default: begin
                            st_d.aw[7:0] = mem_rdata;
                            st_d.cnt     = 2'd0;
                            st_d.phase   = PH_EXEC;
                        end
                    endcase
                end
            end
            PH_EXEC: begin
                st_d.phase = PH_FETCH;
                case (op)
                    OP_ADD, OP_SUB, OP_MUL: begin
                        rf_we   = 1'b1;
                        st_d.fl = alu_fl;
                        st_d.pc = pc2;
                    end
                    OP_AND, OP_OR, OP_XOR, OP_SHL, OP_SHR, OP_DIV: begin
                        rf_we   = 1'b1;
                        st_d.pc = pc2;
                    end
                    OP_CMP: begin
                        st_d.fl = alu_fl;
                        st_d.pc = pc2;
                    end
                    OP_LOAD, OP_STORE: st_d.phase = PH_DATA;
                    OP_JMP:  st_d.pc = tgt;
                    OP_JCC:  st_d.pc = jcc_taken ? tgt : pc4;
                    OP_CALL: begin
                        st_d.sp    = st_q.sp - AW'(1);
                        st_d.phase = PH_PUSH_HI;
                    end
                    default: st_d.phase = PH_STOP;
                endcase
            end
            PH_DATA: begin
                mem_req  = 1'b1;
                mem_addr = tgt;
                mem_we   = (op == OP_STORE);
                if (mem_ready) begin
                    rf_we      = (op == OP_LOAD);
                    st_d.pc    = pc4;
                    st_d.phase = PH_FETCH;
                end
            end
            PH_PUSH_HI: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = st_q.sp;
                mem_wdata = ret_word[15:8];
                if (mem_ready) begin
                    st_d.sp    = st_q.sp - AW'(1);
                    st_d.phase = PH_PUSH_LO;
                end
            end
            PH_PUSH_LO: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = st_q.sp;
                mem_wdata = ret_word[7:0];
                if (mem_ready) begin
                    st_d.pc    = tgt;
                    st_d.phase = PH_FETCH;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_FETCH;
            st_q.cnt   <= '0;
            st_q.pc    <= '0;
            st_q.sp    <= '1;
            st_q.ir    <= '0;
            st_q.aw    <= '0;
            st_q.fl    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic [AW-1:0] sp_q;
    assign sp_q = st_q.sp;

    // R13: an unaccepted request is held unchanged
    a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R13: a write is always part of a request
    a_r13_we_in_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    // R12: halt is sticky
    a_r12_stay_halted: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R12: no bus activity once halted
    a_r12_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_req);

    // R11: the stack pointer only ever moves down by one
    a_r11_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_q != $past(sp_q)) |-> (sp_q == AW'($past(sp_q) - AW'(1))));

endmodule

// File: tb/test_acc8_core.sv
module test_acc8_core;

    localparam int AW   = 10;
    localparam int MSZ  = 1 << AW;
    localparam int DA   = 'h100;
    localparam int DB   = 'h101;
    localparam int DONE = 'h102;
    localparam int RES  = 'h103;
    localparam int FLG  = 'h104;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mem_req, mem_we, mem_ready, halted;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata, mem_rdata;

    logic [7:0] mem [0:MSZ-1];
    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int wait_cnt = 0;
    int hs_bad = 0;
    logic pend_v = 1'b0;
    logic [AW-1:0] pend_a;

    always #10 clk = ~clk;

    acc8_core #(.AW(AW)) i_acc8_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .halted    (halted)
    );

    initial begin
        mem_ready = 1'b0;
        mem_rdata = 8'h00;
    end

    // byte memory with random latency; also watches R13 request stability
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ready = 1'b0;
            wait_cnt  = 0;
            pend_v    = 1'b0;
        end else begin
            if (pend_v && !(mem_req && mem_addr == pend_a)) hs_bad++;
            if (mem_ready) begin
                mem_ready = 1'b0;
                wait_cnt  = int'($urandom % 3);
            end else if (mem_req) begin
                if (wait_cnt == 0) begin
                    if (mem_we) mem[mem_addr] = mem_wdata;
                    else        mem_rdata = mem[mem_addr];
                    mem_ready = 1'b1;
                end else begin
                    wait_cnt--;
                end
            end
            pend_v = mem_req && !mem_ready;
            pend_a = mem_addr;
        end
    end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 190000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put16(input int a, input int v);
        mem[a]   = 8'((v >> 8) & 255);
        mem[a+1] = 8'(v & 255);
    endtask

    task automatic ins(input int a, input int op, input int rd, input int rs, input int imm);
        put16(a, (op << 12) | (rd << 10) | (rs << 8) | (imm & 255));
    endtask

    // R2: random bits above the address width must be ignored
    function automatic int hiaddr(input int x);
        return (x | (int'($urandom % 64) << AW)) & 'hFFFF;
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < MSZ; i++) mem[i] = 8'h00;
    endtask

    task automatic run_prog(input bit check_reset);
        int n;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        if (check_reset) begin
            chk("R1 first request", int'(mem_req), 1);
            chk("R1 first address", int'(mem_addr), 0);
            chk("R1 first is read", int'(mem_we), 0);
            chk("R1 not halted", int'(halted), 0);
        end
        n = 0;
        while (!halted && n < 4000) begin
            @(negedge clk);
            n++;
        end
        chk("R12 reached halt", int'(halted), 1);
        repeat (4) @(negedge clk);
        chk("R12 quiet after halt", int'(halted && !mem_req), 1);
    endtask

    function automatic string rq(input int op);
        case (op)
            0: return "R3";
            1: return "R4";
            2, 3, 4: return "R5";
            5, 6: return "R6";
            7, 8: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic trial(input int op, input int a, input int b, input int inv);
        int r, z, n, c, v, stored, p, s;
        int fv [4];
        clear_mem();
        mem[DA] = 8'(a); mem[DB] = 8'(b); mem[DONE] = 8'd1;
        ins(0, 'hA, 0, 0, 0);  put16(2, hiaddr(DA));
        ins(4, 'hA, 1, 0, 0);  put16(6, hiaddr(DB));
        ins(8, 'hA, 2, 0, 0);  put16(10, hiaddr(DONE));
        ins(12, 9, 2, 2, 0);
        ins(14, op, 0, 1, 0);
        ins(16, 'hB, 0, 0, 0); put16(18, hiaddr(RES));
        for (int k = 0; k < 4; k++) begin
            p = 20 + 4 * k;
            s = 64 + 8 * k;
            ins(p, 'hD, 0, 0, 2 * k + inv); put16(p + 2, hiaddr(s));
            ins(s, 'hB, 0, 2, 0);           put16(s + 2, hiaddr(FLG + k));
            ins(s + 4, 'hC, 0, 0, 0);       put16(s + 6, hiaddr(p + 4));
        end
        ins(36, 'hF, 0, 0, 0);
        // flags after CMP 1,1: Z=1 N=0 C=1 V=0
        z = 1; n = 0; c = 1; v = 0; r = a;
        case (op)
            0: begin
                r = (a + b) & 255; c = int'((a + b) > 255);
                v = int'(((a >> 7) == (b >> 7)) && ((r >> 7) != (a >> 7)));
            end
            1, 9: begin
                r = (a - b) & 255; c = int'(a >= b);
                v = int'(((a >> 7) != (b >> 7)) && ((r >> 7) != (a >> 7)));
            end
            2: r = a & b;
            3: r = a | b;
            4: r = a ^ b;
            5: r = (a << 1) & 255;
            6: r = a >> 1;
            7: begin r = (a * b) & 255; c = 0; v = 0; end
            default: r = (b == 0) ? 255 : a / b;
        endcase
        if (op == 0 || op == 1 || op == 7 || op == 9) begin
            z = int'(r == 0);
            n = r >> 7;
        end
        stored = (op == 9) ? a : r;
        run_prog(1'b0);
        chk($sformatf("%s result op=%0d a=%0h b=%0h (R2 R9)", rq(op), op, a, b), int'(mem[RES]), stored);
        fv[0] = z; fv[1] = c; fv[2] = n; fv[3] = v;
        for (int k = 0; k < 4; k++)
            chk($sformatf("%s flag%0d inv=%0d via R10 op=%0d a=%0h b=%0h", rq(op), k, inv, op, a, b),
                int'(mem[FLG + k]), fv[k] ^ inv);
    endtask

    initial begin
        void'($urandom(32'd7321));
        // R1 reset state, R11 call push order, R2 wrap of address word
        clear_mem();
        mem[RES] = 8'hAA;
        ins(0, 'hB, 0, 3, 0);      put16(2, hiaddr(RES));
        ins(4, 'hC, 0, 0, 0);      put16(6, hiaddr('h1F0));
        ins('h1F0, 'hE, 0, 0, 0);  put16('h1F2, hiaddr('h60));
        ins('h60, 'hF, 0, 0, 0);
        run_prog(1'b1);
        chk("R1 register reset", int'(mem[RES]), 0);
        chk("R11 push high byte", int'(mem[MSZ-2]), 'h01);
        chk("R11 push low byte", int'(mem[MSZ-3]), 'hF4);
        chk("R11 top byte untouched", int'(mem[MSZ-1]), 0);

        // directed corner cases
        trial(0, 'h7F, 'h01, 0);   // R3 signed overflow
        trial(0, 'hFF, 'h01, 1);   // R3 zero with carry
        trial(1, 'h00, 'h01, 0);   // R4 borrow
        trial(1, 'h80, 'h01, 1);   // R4 overflow
        trial(1, 'h05, 'h05, 0);   // R4 zero, no borrow
        trial(7, 'h10, 'h10, 0);   // R7 product wraps to zero
        trial(7, 'h0F, 'h11, 1);   // R7
        trial(8, 200, 7, 0);       // R7 quotient
        trial(8, 'h33, 0, 1);      // R7 divide by zero
        trial(5, 'h81, 0, 0);      // R6
        trial(6, 'h81, 0, 1);      // R6
        trial(9, 3, 5, 0);         // R8
        trial(2, 'hF0, 'h3C, 1);   // R5
        for (int i = 0; i < 60; i++)
            trial(int'($urandom % 10), int'($urandom % 256), int'($urandom % 256), int'($urandom % 2));

        chk("R13 request held until ready", hs_bad, 0);
        summary();
        $finish;
    end

endmodule